// File: doc/BRIEF.md
# Floating-Point Status and Exception Control

This block holds the status/control word of a floating-point unit. Each time the arithmetic datapath finishes an operation it presents five IEEE exception indications: invalid, divide-by-zero, overflow, underflow and inexact. The block then rebuilds the per-operation cause field from them and accumulates them into sticky flags. When a raised cause is also enabled, it emits a one-cycle exception request that carries a fixed code.

The word can be loaded through a write port. Bits outside the writable mask are dropped. On such a load, the block also decodes the rounding-mode field and the denormal control into two steady mode outputs for the datapath. One operation kind, the approximate reciprocal square root, is always reported as inexact when it raised nothing else.

Top module: `fp_status_ctrl`

## Requirements
- R1: After reset, `csr_q` is zero, `exc_req` is low, `exc_code` is zero, `rnd_to_zero` is low and `flush_denorm` is low.
- R2: A cycle with `wr_en` high loads `csr_q` with `wr_data & 32'h003F_FFFF` at the next edge, so bits 31:22 always read zero.
- R3: In the cycle after `op_done` (without `wr_en`), the cause field `csr_q[17:12]` holds `{1'b0, op_flags}`, where `op_flags` bit 4 is invalid, bit 3 is divide-by-zero, bit 2 is overflow, bit 1 is underflow and bit 0 is inexact. Bit 17 is always cleared by an operation.
- R4: An operation ORs its cause bits into the sticky flag field `csr_q[6:2]` (same bit order) and never clears a flag.
- R5: In the cycle after `op_done` (without `wr_en`), `exc_req` is high for exactly that cycle with `exc_code` = 12'h120 if any cause bit is set together with the matching enable bit in `csr_q[11:7]` (same bit order). Otherwise `exc_req` is low and `exc_code` is zero.
- R6: When `op_rsqrt_approx` is high and `op_flags` is zero, the operation is treated as if only inexact (bit 0) were raised. When `op_flags` is nonzero, it is used unchanged.
- R7: A write whose `wr_data[1:0]` equals 2'b01 sets `rnd_to_zero` high from the next cycle. The codes 00, 10 and 11 set it low. Operations leave it unchanged.
- R8: A write sets `flush_denorm` to `wr_data[18]` from the next cycle. Operations leave it unchanged.
- R9: When `wr_en` and `op_done` are high in the same cycle, the write is applied and the operation is discarded: no cause or flag update, and no exception request.
- R10: An operation leaves the rounding-mode field, the enable field, bit 18 and bits 21:19 of `csr_q` unchanged.
- R11: A cycle with neither `wr_en` nor `op_done` leaves `csr_q` unchanged, and `exc_req` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_done | input | 1 | One FP operation completed this cycle |
| op_flags | input | 5 | Exception indications {invalid, div-by-zero, overflow, underflow, inexact} |
| op_rsqrt_approx | input | 1 | The completed operation is the approximate reciprocal square root |
| wr_en | input | 1 | Load the status word |
| wr_data | input | 32 | Value to load (masked) |
| csr_q | output | 32 | Current status/control word |
| exc_req | output | 1 | FP exception request pulse |
| exc_code | output | 12 | Exception code, 12'h120 while exc_req is high, else zero |
| rnd_to_zero | output | 1 | Datapath rounds by truncation |
| flush_denorm | output | 1 | Datapath flushes denormals to zero |

## Verification
Directed operations raise each indication alone, with its enable set and with it cleared. This separates a wrong bit position in the cause or flag field from a wrong enable pairing in the trap. The reciprocal-square-root case is driven with zero and with nonzero indications, which shows whether the forced inexact is conditional. Write cycles sweep all four rounding codes and both denormal settings, and include all-ones data to expose the mask. Write and operation are driven together to check the precedence. Random sequences of writes, operations and idle cycles, compared against a bench model, test that flags stay sticky across many operations while the cause field is rebuilt each time.

// File: rtl/fp_status_pkg.sv
package fp_status_pkg;
  localparam int unsigned CSR_W      = 32;
  localparam int unsigned NUM_EXC    = 5;
  localparam int unsigned RM_W       = 2;
  localparam int unsigned RM_LSB     = 0;
  localparam int unsigned FLAG_LSB   = 2;
  localparam int unsigned ENA_LSB    = FLAG_LSB + NUM_EXC;
  localparam int unsigned CAUSE_LSB  = ENA_LSB + NUM_EXC;
  localparam int unsigned CAUSE_W    = NUM_EXC + 1;
  localparam int unsigned DN_BIT     = CAUSE_LSB + CAUSE_W;
  localparam int unsigned CODE_W     = 12;

  localparam logic [CSR_W-1:0]  WR_MASK   = 32'h003F_FFFF;
  localparam logic [RM_W-1:0]   RM_TRUNC  = 2'b01;
  localparam logic [CODE_W-1:0] FPE_CODE  = 12'h120;

  // position of each indication inside a five-bit field
  typedef enum int unsigned {
    EXC_INEXACT   = 0,
    EXC_UNDERFLOW = 1,
    EXC_OVERFLOW  = 2,
    EXC_DIVZERO   = 3,
    EXC_INVALID   = 4
  } exc_idx_e;
endpackage

// File: rtl/fp_cause_gen.sv
module fp_cause_gen #(
  parameter int unsigned NUM_EXC     = 5,
  parameter int unsigned INEXACT_IDX = 0
) (
  input  logic [NUM_EXC-1:0] raw_flags,
  input  logic               rsqrt_approx,
  output logic [NUM_EXC-1:0] cause_bits
);
  logic force_inexact;

  always_comb begin
    force_inexact = rsqrt_approx && (raw_flags == '0);
  end

  for (genvar g = 0; g < NUM_EXC; g++) begin : g_bit
    if (g == INEXACT_IDX) begin : g_inx
      assign cause_bits[g] = raw_flags[g] | force_inexact;
    end else begin : g_other
      assign cause_bits[g] = raw_flags[g];
    end
  end
endmodule

// File: rtl/fp_trap_eval.sv
module fp_trap_eval #(
  parameter int unsigned NUM_EXC = 5
) (
  input  logic [NUM_EXC-1:0] cause_bits,
  input  logic [NUM_EXC-1:0] enable_bits,
  output logic               trap_hit
);
  logic [NUM_EXC-1:0] hit_vec;

  for (genvar g = 0; g < NUM_EXC; g++) begin : g_and
    assign hit_vec[g] = cause_bits[g] & enable_bits[g];
  end

  always_comb begin
    trap_hit = |hit_vec;
  end
endmodule

// File: rtl/fp_mode_decode.sv
module fp_mode_decode #(
  parameter int unsigned    RM_W     = 2,
  parameter logic [RM_W-1:0] RM_TRUNC = 2'b01
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [RM_W-1:0] rm_field,
  input  logic            dn_bit,
  output logic            rtz_q,
  output logic            ftz_q
);
  logic rtz_d;
  logic ftz_d;

  always_comb begin
    rtz_d = (rm_field == RM_TRUNC);
    ftz_d = dn_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rtz_q <= 1'b0;
      ftz_q <= 1'b0;
    end else if (load_en) begin
      rtz_q <= rtz_d;
      ftz_q <= ftz_d;
    end
  end
endmodule

// File: rtl/fp_status_ctrl.sv
module fp_status_ctrl
  import fp_status_pkg::*;
#(
  parameter int unsigned       W       = CSR_W,
  parameter logic [CSR_W-1:0]  WMASK   = WR_MASK
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_done,
  input  logic [NUM_EXC-1:0]   op_flags,
  input  logic                 op_rsqrt_approx,
  input  logic                 wr_en,
  input  logic [W-1:0]         wr_data,
  output logic [W-1:0]         csr_q,
  output logic                 exc_req,
  output logic [CODE_W-1:0]    exc_code,
  output logic                 rnd_to_zero,
  output logic                 flush_denorm
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [NUM_EXC-1:0] cause_bits;
  logic               trap_hit;
  logic               op_take;
  logic [W-1:0]       csr_d;
  logic               csr_en;
  logic               exc_d;
  logic [CODE_W-1:0]  code_d;
  logic [W-1:0]       wr_masked;

  fp_cause_gen #(
    .NUM_EXC    (NUM_EXC),
    .INEXACT_IDX(EXC_INEXACT)
  ) u_cause (
    .raw_flags   (op_flags),
    .rsqrt_approx(op_rsqrt_approx),
    .cause_bits  (cause_bits)
  );

  fp_trap_eval #(
    .NUM_EXC(NUM_EXC)
  ) u_trap (
    .cause_bits (cause_bits),
    .enable_bits(csr_q[ENA_LSB +: NUM_EXC]),
    .trap_hit   (trap_hit)
  );

  always_comb begin
    wr_masked = wr_data & WMASK;
    op_take   = op_done & ~wr_en;
    csr_en    = wr_en | op_done;
    csr_d     = csr_q;
    if (wr_en) begin
      csr_d = wr_masked;
    end else if (op_done) begin
      csr_d[CAUSE_LSB +: CAUSE_W] = '0;
      csr_d[CAUSE_LSB +: NUM_EXC] = cause_bits;
      csr_d[FLAG_LSB  +: NUM_EXC] = csr_q[FLAG_LSB +: NUM_EXC] | cause_bits;
    end
    exc_d  = op_take & trap_hit;
    code_d = exc_d ? FPE_CODE : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      csr_q <= '0;
    end else if (csr_en) begin
      csr_q <= csr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      exc_req  <= 1'b0;
      exc_code <= '0;
    end else begin
      exc_req  <= exc_d;
      exc_code <= code_d;
    end
  end

  fp_mode_decode #(
    .RM_W    (RM_W),
    .RM_TRUNC(RM_TRUNC)
  ) u_mode (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_en (wr_en),
    .rm_field(wr_masked[RM_LSB +: RM_W]),
    .dn_bit  (wr_masked[DN_BIT]),
    .rtz_q   (rnd_to_zero),
    .ftz_q   (flush_denorm)
  );
endmodule

module fp_status_ctrl_chk
  import fp_status_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               op_done,
  input logic [NUM_EXC-1:0] op_flags,
  input logic               op_rsqrt_approx,
  input logic               wr_en,
  input logic [CSR_W-1:0]   wr_data,
  input logic [CSR_W-1:0]   csr_q,
  input logic               exc_req,
  input logic [CODE_W-1:0]  exc_code,
  input logic               rnd_to_zero,
  input logic               flush_denorm
);
  logic [NUM_EXC-1:0] eff_flags;
  always_comb begin
    eff_flags = op_flags;
    if (op_rsqrt_approx && op_flags == '0) eff_flags = 5'b00001;
  end

  // R2
  wr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (csr_q == ($past(wr_data) & WR_MASK)));

  // R3
  cause_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !wr_en) |=> (csr_q[CAUSE_LSB +: CAUSE_W] == {1'b0, $past(eff_flags)}));

  // R4
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !wr_en) |=>
      ((csr_q[FLAG_LSB +: NUM_EXC] & $past(csr_q[FLAG_LSB +: NUM_EXC])) ==
        $past(csr_q[FLAG_LSB +: NUM_EXC])));

  // R5
  exc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> ($past(op_done) && !$past(wr_en) && exc_code == FPE_CODE));

  // R7
  rtz_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_to_zero == (csr_q[1:0] == RM_TRUNC));

  // R8
  dn_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_denorm == csr_q[DN_BIT]);

  // R11
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !op_done) |=> ($stable(csr_q) && !exc_req));
endmodule

bind fp_status_ctrl fp_status_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .op_done        (op_done),
  .op_flags       (op_flags),
  .op_rsqrt_approx(op_rsqrt_approx),
  .wr_en          (wr_en),
  .wr_data        (wr_data),
  .csr_q          (csr_q),
  .exc_req        (exc_req),
  .exc_code       (exc_code),
  .rnd_to_zero    (rnd_to_zero),
  .flush_denorm   (flush_denorm)
);

// File: tb/fp_status_ctrl_tb.sv
module fp_status_ctrl_tb_top;
  logic        clk;
  logic        rst_n;
  logic        op_done;
  logic [4:0]  op_flags;
  logic        op_rsqrt_approx;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] csr_q;
  logic        exc_req;
  logic [11:0] exc_code;
  logic        rnd_to_zero;
  logic        flush_denorm;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] m_csr;
  logic        m_exc;
  logic        m_rtz;
  logic        m_ftz;

  localparam logic [31:0] MASK = 32'h003F_FFFF;

  fp_status_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .op_done(op_done), .op_flags(op_flags),
    .op_rsqrt_approx(op_rsqrt_approx), .wr_en(wr_en), .wr_data(wr_data),
    .csr_q(csr_q), .exc_req(exc_req), .exc_code(exc_code),
    .rnd_to_zero(rnd_to_zero), .flush_denorm(flush_denorm)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [4:0] f_eff(input logic [4:0] fl, input logic rs);
    return (rs && fl == 5'd0) ? 5'b00001 : fl;
  endfunction

  function automatic logic [31:0] f_upd(input logic [31:0] c, input logic [4:0] fl, input logic rs);
    logic [31:0] r;
    logic [4:0]  e;
    e = f_eff(fl, rs);
    r = c;
    r[17:12] = {1'b0, e};
    r[6:2]   = c[6:2] | e;
    return r;
  endfunction

  function automatic logic f_trap(input logic [31:0] c, input logic [4:0] fl, input logic rs);
    return |(f_eff(fl, rs) & c[11:7]);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " csr"}, csr_q, m_csr);
    chk({req, " exc"}, {31'd0, exc_req}, {31'd0, m_exc});
    chk({req, " code"}, {20'd0, exc_code}, m_exc ? 32'h120 : 32'h0);
    chk({req, " rtz"}, {31'd0, rnd_to_zero}, {31'd0, m_rtz});
    chk({req, " dn"}, {31'd0, flush_denorm}, {31'd0, m_ftz});
  endtask

  // one clock: drive at negedge, check after the next edge at negedge
  task automatic cyc(input string req, input logic w, input logic [31:0] wd,
                     input logic od, input logic [4:0] fl, input logic rs);
    wr_en = w; wr_data = wd; op_done = od; op_flags = fl; op_rsqrt_approx = rs;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; op_done = 0; op_flags = 0; op_rsqrt_approx = 0; wr_data = 0;
    if (w) begin
      m_csr = wd & MASK;
      m_rtz = (wd[1:0] == 2'b01);
      m_ftz = wd[18];
      m_exc = 0;
    end else if (od) begin
      m_exc = f_trap(m_csr, fl, rs);
      m_csr = f_upd(m_csr, fl, rs);
    end else begin
      m_exc = 0;
    end
    check_all(req);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; wr_en = 0; wr_data = 0; op_done = 0; op_flags = 0; op_rsqrt_approx = 0;
    m_csr = 0; m_exc = 0; m_rtz = 0; m_ftz = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check_all("R1");

    // R2: all ones masked
    cyc("R2", 1, 32'hFFFF_FFFF, 0, 0, 0);
    // R7 / R8 sweep of rounding codes and denormal bit
    cyc("R7", 1, 32'h0000_0000, 0, 0, 0);
    cyc("R7", 1, 32'h0000_0001, 0, 0, 0);
    cyc("R7", 1, 32'h0004_0002, 0, 0, 0);
    cyc("R8", 1, 32'h0004_0003, 0, 0, 0);
    cyc("R7", 1, 32'h0000_0001, 0, 0, 0);
    // R3/R4/R5: each indication alone, disabled then enabled
    for (int i = 0; i < 5; i++) begin
      cyc("R3", 1, 32'h0000_0001, 0, 0, 0);
      cyc("R3", 0, 0, 1, 5'(1 << i), 0);
      cyc("R11", 0, 0, 0, 0, 0);
      cyc("R5", 1, 32'h0038_0000 | (32'h80 << i), 0, 0, 0);
      cyc("R5", 0, 0, 1, 5'(1 << i), 0);
      cyc("R5", 0, 0, 0, 0, 0);
    end
    // R4: flags remain after an operation with no indications
    cyc("R4", 1, 32'h0000_007C, 0, 0, 0);
    cyc("R4", 0, 0, 1, 5'd0, 0);
    // R6: forced inexact, enabled
    cyc("R6", 1, 32'h0000_0080, 0, 0, 0);
    cyc("R6", 0, 0, 1, 5'd0, 1);
    cyc("R6", 0, 0, 1, 5'b00100, 1);
    // R9: write and op together
    cyc("R9", 1, 32'h0000_0F80, 0, 0, 0);
    cyc("R9", 1, 32'h0004_0F81, 1, 5'b11111, 1);
    // R10: op keeps RM, enables, DN, upper writable bits
    cyc("R10", 1, 32'h0038_0001, 0, 0, 0);
    cyc("R10", 0, 0, 1, 5'b10101, 0);
    // random mix
    for (int k = 0; k < 400; k++) begin
      int sel;
      sel = $urandom_range(0, 9);
      if (sel < 2)
        cyc("R2", 1, $urandom(), 0, 0, 0);
      else if (sel < 7)
        cyc("R4", 0, 0, 1, 5'($urandom_range(0, 31)), ($urandom_range(0, 3) == 0));
      else if (sel < 8)
        cyc("R9", 1, $urandom(), 1, 5'($urandom_range(0, 31)), 0);
      else
        cyc("R11", 0, 0, 0, 0, 0);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule